// File: doc/BRIEF.md
# ChaCha Keystream Block Engine

This core computes one ChaCha keystream block per start strobe. A caller gives sixteen 32-bit words of initial state on a 512-bit bus and pulses `start`. The core copies the words into a working set and keeps a second copy of the originals. It then runs the double rounds one fused step per clock. When the rounds are over, it adds each working word to its original and presents the 64-byte result on `block_out`.

The datapath is a single step unit. It adds two words modulo 2^32, XORs that sum into a third word and rotates the result left by 16, 12, 8 or 7. The unit returns both the plain sum and the rotated value, and both go back into the working set. Four such steps make a quarter-round. A small scheduler walks the column and diagonal quarter-rounds and counts the rounds down by two per double round.

Key layout, nonce layout, block-counter stepping and the message XOR are left to the caller.

Top module: `kstream_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `block_out` is all zero.
- R2: A `start` sampled high while `busy` is low is accepted. On the next cycle `busy` is 1 and `done` is 0.
- R3: A `start` sampled while `busy` is high has no effect. It does not change the result or the completion time of the block in progress.
- R4: The step count is set by the `ROUNDS` parameter, which must be even and at least 2. It is ROUNDS/2 double rounds of 8 quarter-rounds of 4 steps, one step per clock. With the accepting edge as edge 0, `done` rises at edge ROUNDS*16+1: 321 for 20 rounds and 33 for 2 rounds.
- R5: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R6: The step unit forms s = x + y mod 2^32 and returns {rotl(s ^ z, n), s}, with the rotated value in bits 63:32. The 2-bit code sets n: 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 7.
- R7: With input words 0..3 = 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574 and all other words zero, the output equals the standard 20-round all-zero-key, all-zero-nonce keystream block.
- R8: The output is the ChaCha block function of the input. Each quarter-round on (a,b,c,d) does a+=b, d=rotl(d^a,16); c+=d, b=rotl(b^c,12); a+=b, d=rotl(d^a,8); c+=d, b=rotl(b^c,7). Each double round runs the columns (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15) and then the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). Finally each word is added to its input word modulo 2^32.
- R9: Word i of the input is bits 32i+31:32i of `state_in`. Output word i is bits 32i+31:32i of `block_out`, so output byte k is bits 8k+7:8k and each word is sent least significant byte first.
- R10: `block_out` changes only in the cycle where `done` is high, and holds its value until the next accepted block completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block when idle |
| state_in | input | 512 | Sixteen input words, word i at bits 32i+31:32i |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |
| block_out | output | 512 | Keystream block, byte k at bits 8k+7:8k |

## Verification
The bench builds the core twice: once with the default of 20 rounds, and once with `ROUNDS` = 2. The 20-round build is checked against the known all-zero keystream block. It is also checked against an independent model on several seeded states. A start pulse is injected mid-block to show it has no effect. The 2-round build brings the short-schedule latency of 33 and the end of the round countdown into a few dozen cycles. The bench also drives the step unit alone with all four rotate codes.

// File: rtl/kstream_pkg.sv
package kstream_pkg;
  localparam int WORD_W = 32;
  localparam int N_WORDS = 16;
  typedef logic [WORD_W-1:0] word_t;

  // rotate distance chosen by the 2-bit step code
  function automatic int unsigned rot_amount(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 12;
      2'd2:    return 8;
      default: return 7;
    endcase
  endfunction

  function automatic word_t rotl32(input word_t v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  // role 0..3 = a,b,c,d ; quarter 0..3 columns, 4..7 diagonals
  function automatic logic [3:0] word_index(input logic [2:0] quarter, input logic [1:0] role);
    logic [1:0] lane;
    lane = quarter[1:0] + (quarter[2] ? role : 2'd0);
    return {role, lane};
  endfunction
endpackage

// File: rtl/kstream_step.sv
module kstream_step
  import kstream_pkg::*;
(
  input  word_t       x,
  input  word_t       y,
  input  word_t       z,
  input  logic [1:0]  code,
  output logic [63:0] pair
);
  word_t       sum_w;
  word_t       rot_w;
  int unsigned amt;

  always_comb begin
    amt   = rot_amount(code);
    sum_w = x + y;
    rot_w = rotl32(sum_w ^ z, amt);
    pair  = {rot_w, sum_w};
  end

  // undoing the rotation must recover sum ^ z
  always_comb begin
    assert_rot_inverse_R6: assert (((pair[63:32] >> amt) | (pair[63:32] << (WORD_W - amt)))
                                   == (pair[31:0] ^ z));
  end
endmodule

// File: rtl/kstream_sched.sv
module kstream_sched #(
  parameter int ROUNDS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  output logic       step_en,
  output logic [1:0] code,
  output logic [2:0] qsel,
  output logic       last_step
);
  localparam int RLW = $clog2(ROUNDS + 1);

  logic           act_q;
  logic [1:0]     s_q;
  logic [2:0]     q_q;
  logic [RLW-1:0] rl_q;
  logic           qr_end;
  logic           dr_end;

  assign qr_end    = act_q && (s_q == 2'd3);
  assign dr_end    = qr_end && (q_q == 3'd7);
  assign last_step = dr_end && (rl_q == RLW'(2));
  assign step_en   = act_q;
  assign code      = s_q;
  assign qsel      = q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      s_q   <= '0;
      q_q   <= '0;
      rl_q  <= '0;
    end else if (go) begin
      act_q <= 1'b1;
      s_q   <= '0;
      q_q   <= '0;
      rl_q  <= RLW'(ROUNDS);
    end else if (act_q) begin
      s_q <= s_q + 2'd1;
      if (qr_end) q_q <= q_q + 3'd1;
      if (dr_end) rl_q <= rl_q - RLW'(2);
      if (last_step) act_q <= 1'b0;
    end
  end

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_end && !last_step && !go) |=> (rl_q == $past(rl_q) - RLW'(2)));
  assert_active_rounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (rl_q != '0));
  assert_stop_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && !go) |=> !act_q);
endmodule

// File: rtl/kstream_core.sv
module kstream_core
  import kstream_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [511:0] state_in,
  output logic         busy,
  output logic         done,
  output logic [511:0] block_out
);
  word_t       work [N_WORDS];
  word_t       orig [N_WORDS];
  logic        accept;
  logic        step_en;
  logic        last_step;
  logic        fin_pend;
  logic [1:0]  code;
  logic [2:0]  qsel;
  logic [3:0]  ix_x, ix_y, ix_z;
  logic [63:0] pair;

  assign accept = start && !busy;

  kstream_sched #(.ROUNDS(ROUNDS)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (accept),
    .step_en   (step_en),
    .code      (code),
    .qsel      (qsel),
    .last_step (last_step)
  );

  // even steps: a += b, d ^= a ; odd steps: c += d, b ^= c
  always_comb begin
    ix_x = word_index(qsel, code[0] ? 2'd2 : 2'd0);
    ix_y = word_index(qsel, code[0] ? 2'd3 : 2'd1);
    ix_z = word_index(qsel, code[0] ? 2'd1 : 2'd3);
  end

  kstream_step u_step (
    .x    (work[ix_x]),
    .y    (work[ix_y]),
    .z    (work[ix_z]),
    .code (code),
    .pair (pair)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fin_pend  <= 1'b0;
      block_out <= '0;
      for (int i = 0; i < N_WORDS; i++) begin
        work[i] <= '0;
        orig[i] <= '0;
      end
    end else begin
      done     <= 1'b0;
      fin_pend <= step_en && last_step;
      if (accept) begin
        busy <= 1'b1;
        for (int i = 0; i < N_WORDS; i++) begin
          work[i] <= state_in[WORD_W*i +: WORD_W];
          orig[i] <= state_in[WORD_W*i +: WORD_W];
        end
      end else if (step_en) begin
        work[ix_x] <= pair[31:0];
        work[ix_z] <= pair[63:32];
      end
      if (fin_pend) begin
        for (int i = 0; i < N_WORDS; i++)
          block_out[WORD_W*i +: WORD_W] <= work[i] + orig[i];
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !done));
  assert_ignore_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !fin_pend) |=> busy);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(block_out));
endmodule

// File: tb/test_kstream_core.sv
module test_kstream_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         start_a = 1'b0, start_b = 1'b0;
  logic [511:0] st_a = '0, st_b = '0;
  logic         busy_a, done_a, busy_b, done_b;
  logic [511:0] out_a, out_b;

  kstream_core i_kstream_core (
    .clk(clk), .rst_n(rst_n), .start(start_a), .state_in(st_a),
    .busy(busy_a), .done(done_a), .block_out(out_a)
  );

  kstream_core #(.ROUNDS(2)) i_kstream_core_r2 (
    .clk(clk), .rst_n(rst_n), .start(start_b), .state_in(st_b),
    .busy(busy_b), .done(done_b), .block_out(out_b)
  );

  logic [31:0] sx = '0, sy = '0, sz = '0;
  logic [1:0]  scode = '0;
  logic [63:0] spair;
  kstream_step i_step (.x(sx), .y(sy), .z(sz), .code(scode), .pair(spair));

  int total = 0;
  int bad = 0;

  localparam logic [31:0] SEEDS [4] = '{32'h0, 32'hdeadbeef, 32'h01234567, 32'hffffffff};

  localparam logic [511:0] ZERO_KS = {
    32'h8665eeb2, 32'h69b687c3, 32'h1ca11815, 32'hf4b8436a,
    32'h374ad8b8, 32'h3fe02477, 32'h8d485751, 32'h7c5941da,
    32'hc70d778b, 32'hccef36a8, 32'h1aed8da0, 32'hb819d2bd,
    32'h28bd8653, 32'he56a5d40, 32'h903df1a0, 32'hade0b876};

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    logic [63:0] d;
    d = {v, v} << n;
    return d[63:32];
  endfunction

  function automatic logic [511:0] ref_block(input logic [511:0] st, input int rounds);
    logic [31:0] w [16];
    logic [31:0] a, b, c, d;
    int          qa [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    int          qb [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
    int          qc [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
    int          qd [8] = '{12, 13, 14, 15, 15, 12, 13, 14};
    logic [511:0] r;
    for (int i = 0; i < 16; i++) w[i] = st[32*i +: 32];
    for (int k = 0; k < rounds / 2; k++) begin
      for (int q = 0; q < 8; q++) begin
        a = w[qa[q]]; b = w[qb[q]]; c = w[qc[q]]; d = w[qd[q]];
        a = a + b; d = rl(d ^ a, 16);
        c = c + d; b = rl(b ^ c, 12);
        a = a + b; d = rl(d ^ a, 8);
        c = c + d; b = rl(b ^ c, 7);
        w[qa[q]] = a; w[qb[q]] = b; w[qc[q]] = c; w[qd[q]] = d;
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = w[i] + st[32*i +: 32];
    return r;
  endfunction

  function automatic logic [511:0] seed_state(input logic [31:0] s);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = (s * (i + 3)) ^ {4{8'(i * 17)}};
    return r;
  endfunction

  // which: 0 = 20-round build, 1 = 2-round build; pulse_at injects a start while busy
  task automatic run_block(input bit which, input logic [511:0] st, input int pulse_at, output int lat);
    @(negedge clk);
    if (which) begin st_b = st; start_b = 1'b1; end
    else begin st_a = st; start_a = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    lat = 0;
    chk((which ? busy_b : busy_a) && !(which ? done_b : done_a), "R2 busy after accept",
        {511'd0, which ? busy_b : busy_a}, 512'd1);
    while (!(which ? done_b : done_a) && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (lat == pulse_at && !which) begin start_a = 1'b1; st_a = ~st; end
      else begin start_a = 1'b0; start_b = 1'b0; end
    end
    start_a = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [511:0] hold;
    logic [511:0] zst;
    logic [31:0]  sm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_a && !done_a, "R1 flags after reset", {510'd0, busy_a, done_a}, 512'd0);
    chk(out_a == '0, "R1 output after reset", out_a, 512'd0);

    // R6 step unit, all codes
    sx = 32'h11111111; sy = 32'h01020304; sz = 32'h01234567;
    for (int c = 0; c < 4; c++) begin
      int n;
      n = (c == 0) ? 16 : (c == 1) ? 12 : (c == 2) ? 8 : 7;
      scode = 2'(c);
      #1;
      sm = sx + sy;
      chk(spair == {rl(sm ^ sz, n), sm}, "R6 step code", {448'd0, spair}, {448'd0, rl(sm ^ sz, n), sm});
    end

    // R7, R3, R4, R5, R9 on the zero-key block with a mid-block start
    zst = '0;
    zst[127:0] = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
    run_block(1'b0, zst, 5, lat);
    chk(lat == 321, "R4 latency 20 rounds (R3 ignored start)", 512'(lat), 512'd321);
    chk(!busy_a, "R5 busy low with done", {511'd0, busy_a}, 512'd0);
    chk(out_a == ZERO_KS, "R7 R9 R3 zero-key keystream", out_a, ZERO_KS);
    hold = out_a;
    @(negedge clk);
    chk(!done_a, "R5 done single cycle", {511'd0, done_a}, 512'd0);
    repeat (6) @(negedge clk);
    chk(out_a == hold, "R10 output held while idle", out_a, hold);

    // R8 table walk against the model
    for (int t = 0; t < 4; t++) begin
      logic [511:0] s;
      s = seed_state(SEEDS[t]);
      run_block(1'b0, s, 0, lat);
      chk(out_a == ref_block(s, 20), "R8 model match", out_a, ref_block(s, 20));
      chk(lat == 321, "R4 latency table", 512'(lat), 512'd321);
    end

    // R4, R8 with the 2-round build
    run_block(1'b1, seed_state(32'h5a5a1234), 0, lat);
    chk(lat == 33, "R4 latency 2 rounds", 512'(lat), 512'd33);
    chk(out_b == ref_block(seed_state(32'h5a5a1234), 2), "R8 two-round model",
        out_b, ref_block(seed_state(32'h5a5a1234), 2));
    hold = out_b;
    run_block(1'b1, zst, 0, lat);
    chk(out_b == ref_block(zst, 2) && out_b != hold, "R10 new result after next block",
        out_b, ref_block(zst, 2));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule